// File: doc/BRIEF.md
# Pipelined Zero-Gap Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous static RAM whose read and write cycles share a two-stage pipeline. Because of that shared pipeline, a read can follow a write on the very next clock with no idle turnaround cycle. The data word is 36 bits wide. It is split into four 9-bit lanes, and each lane carries one byte plus one parity bit. The array holds 256 words.

A controller starts an access by holding `load_n` low. In that cycle it presents an address, the cycle type on `wr_n`, and three chip selects. In later cycles it can hold `load_n` high to step through a four-word burst. The burst reuses the cycle type and the select state that were captured at the load. Write data for an access is taken two enabled clock edges after its address. Read data and `rvalid` appear two enabled edges after the address.

Two inputs override normal operation. `clk_en_n` can freeze the whole block. `sleep` is asynchronous: while it is high, every other input is shut out.

Top module: `pipe_sram`

## Requirements
- R1: After reset, `rvalid` is 0 and `rdata` is 0.
- R2: A selected read loaded at enabled edge k updates `rdata` at enabled edge k+2 with the stored word at its address, and `rvalid` is 1 for that data cycle. In other data cycles `rvalid` is 0.
- R3: For a selected write, `wdata` is sampled at the second enabled edge after the address. Lane i is bits [9i+8:9i], and it is written only if `lane_we_n[i]` was 0 in the address cycle. With all four bits at 0, the whole word is written.
- R4: While `clk_en_n` is 1, clock edges have no effect. The array, the burst state, the pipeline, `rdata` and `rvalid` all hold.
- R5: `wr_n` (0 = write, 1 = read) and the chip selects are sampled only when `load_n` is 0. The block is selected only when `cs1_n`=0, `cs2_n`=0 and `cs3`=1.
- R6: An enabled cycle with `load_n`=1 advances the burst. Address bits [1:0] increment modulo 4, while bits [7:2], the cycle type and the select state are kept.
- R7: A deselected access writes nothing, and `rvalid` is 0 in its data cycle. Bursts that advance from a deselected load stay deselected.
- R8: While `sleep` is 1, the array does not change and `rvalid` is 0. Pipelined accesses and the burst select are cleared. The array keeps its contents.
- R9: A read of an address issued on the cycle right after a write to that same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline and burst state |
| sleep | input | 1 | Asynchronous sleep; blocks every other input |
| clk_en_n | input | 1 | Active-low clock enable; 1 freezes the block |
| load_n | input | 1 | 0 = load a new address, 1 = advance the burst |
| wr_n | input | 1 | Cycle type on load: 0 write, 1 read |
| cs1_n | input | 1 | Active-low chip select |
| cs2_n | input | 1 | Active-low chip select |
| cs3 | input | 1 | Active-high chip select |
| addr | input | 8 | Word address |
| lane_we_n | input | 4 | Active-low per-lane write enables, taken in the address cycle |
| wdata | input | 36 | Write data, taken two enabled edges after the address |
| rdata | output | 36 | Registered read data |
| rvalid | output | 1 | High in the data cycle of a selected read |

## Verification
The assertions assume that `sleep` changes only away from a rising clock edge. They also assume that a sleep pulse never begins and ends within one clock period, because a pulse like that would clear state between two samples and break the hold and burst properties. The stimulus changes every input, `sleep` included, only at falling edges and keeps `sleep` high for whole cycles. It also drives `clk_en_n` only at falling edges, so each frozen cycle lasts a whole period.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
    typedef enum logic {
        CYC_READ  = 1'b0,
        CYC_WRITE = 1'b1
    } cyc_e;
endpackage

// File: rtl/pss_front.sv
// Address/burst front end: captures type and select on load, steps burst.
module pss_front
    import pipe_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int BW = 2,
    parameter int NL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic          clk_en_n,
    input  logic          load_n,
    input  logic          wr_n,
    input  logic          cs1_n,
    input  logic          cs2_n,
    input  logic          cs3,
    input  logic [AW-1:0] addr,
    input  logic [NL-1:0] lane_we_n,
    output logic          op_valid,
    output cyc_e          op_kind,
    output logic [AW-1:0] op_addr,
    output logic [NL-1:0] op_lanes
);
    localparam logic [BW-1:0] STEP = {{(BW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [AW-1:0] addr;
        cyc_e          kind;
        logic          sel;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (!load_n) begin
            ctx_d.addr = addr;
            ctx_d.kind = wr_n ? CYC_READ : CYC_WRITE;
            ctx_d.sel  = !cs1_n && !cs2_n && cs3;
        end else begin
            ctx_d.addr[BW-1:0] = ctx_q.addr[BW-1:0] + STEP;
        end
        op_valid = ctx_d.sel;
        op_kind  = ctx_d.kind;
        op_addr  = ctx_d.addr;
        op_lanes = ~lane_we_n;
    end

    always_ff @(posedge clk or negedge rst_n or posedge sleep) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else if (sleep) begin
            ctx_q <= '{addr: ctx_q.addr, kind: ctx_q.kind, sel: 1'b0};
        end else if (!clk_en_n) begin
            ctx_q <= ctx_d;
        end
    end

    // R6: advance keeps high bits, type and select; low bits step by one
    a_r6_burst_step: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        (!clk_en_n && load_n) |=>
            (ctx_q.addr[AW-1:BW] == $past(ctx_q.addr[AW-1:BW])) &&
            (ctx_q.addr[BW-1:0] == BW'($past(ctx_q.addr[BW-1:0]) + STEP)) &&
            (ctx_q.kind == $past(ctx_q.kind)) &&
            (ctx_q.sel == $past(ctx_q.sel)));

    // R5: the type is taken from wr_n only on a load
    a_r5_type_on_load: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        (!clk_en_n && !load_n) |=>
            (ctx_q.kind == ($past(wr_n) ? CYC_READ : CYC_WRITE)));

    // R4: frozen edge keeps burst state
    a_r4_front_hold: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        clk_en_n |=> $stable(ctx_q));
endmodule

// File: rtl/pss_pipe.sv
// Two-stage delay that lines each access up with its data cycle.
module pss_pipe
    import pipe_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int NL = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic          clk_en_n,
    input  logic          in_valid,
    input  cyc_e          in_kind,
    input  logic [AW-1:0] in_addr,
    input  logic [NL-1:0] in_lanes,
    output logic          out_valid,
    output cyc_e          out_kind,
    output logic [AW-1:0] out_addr,
    output logic [NL-1:0] out_lanes
);
    typedef struct packed {
        logic          valid;
        cyc_e          kind;
        logic [AW-1:0] addr;
        logic [NL-1:0] lanes;
    } stage_t;

    typedef struct packed {
        stage_t s1;
        stage_t s2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        if (!clk_en_n) begin
            pipe_d.s1 = '{valid: in_valid, kind: in_kind, addr: in_addr, lanes: in_lanes};
            pipe_d.s2 = pipe_q.s1;
        end
        out_valid = pipe_q.s2.valid;
        out_kind  = pipe_q.s2.kind;
        out_addr  = pipe_q.s2.addr;
        out_lanes = pipe_q.s2.lanes;
    end

    always_ff @(posedge clk or negedge rst_n or posedge sleep) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else if (sleep) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    // R4: frozen edge keeps both stages
    a_r4_pipe_hold: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        clk_en_n |=> $stable(pipe_q));

    // R2: each enabled edge moves stage one into stage two
    a_r2_pipe_shift: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        !clk_en_n |=> (pipe_q.s2 == $past(pipe_q.s1)));
endmodule

// File: rtl/pss_array.sv
// Lane-split storage with registered read port.
module pss_array
    import pipe_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int NL = 4,
    parameter int LW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             clk_en_n,
    input  logic             op_valid,
    input  cyc_e             op_kind,
    input  logic [AW-1:0]    op_addr,
    input  logic [NL-1:0]    op_lanes,
    input  logic [NL*LW-1:0] wdata,
    output logic [NL*LW-1:0] rdata,
    output logic             rvalid
);
    localparam int DEPTH = 1 << AW;
    localparam int DW    = NL * LW;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } out_t;

    out_t             out_d, out_q;
    logic [DW-1:0]    rd_word;
    logic [NL-1:0]    lane_wr;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LW-1:0] bank [DEPTH];

        assign lane_wr[g] = !sleep && !clk_en_n && op_valid &&
                            (op_kind == CYC_WRITE) && op_lanes[g];

        always_ff @(posedge clk) begin
            if (lane_wr[g]) begin
                bank[op_addr] <= wdata[g*LW +: LW];
            end
        end

        assign rd_word[g*LW +: LW] = bank[op_addr];
    end

    always_comb begin
        out_d = out_q;
        if (!clk_en_n) begin
            out_d.valid = op_valid && (op_kind == CYC_READ);
            if (out_d.valid) begin
                out_d.data = rd_word;
            end
        end
        rdata  = out_q.data;
        rvalid = out_q.valid;
    end

    always_ff @(posedge clk or negedge rst_n or posedge sleep) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (sleep) begin
            out_q <= '{valid: 1'b0, data: out_q.data};
        end else begin
            out_q <= out_d;
        end
    end

    // R8: nothing is presented as valid while asleep
    a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rvalid);

    // R7: a bubble in the data slot gives no valid data
    a_r7_bubble: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        (!clk_en_n && !op_valid) |=> !rvalid);

    // R2: a selected read in the data slot gives valid data next
    a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n || sleep)
        (!clk_en_n && op_valid && op_kind == CYC_READ) |=> rvalid);

    // R3: no lane is written by a read access
    a_r3_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == CYC_READ) |-> (lane_wr == '0));
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
    import pipe_sram_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sleep,
    input  logic                      clk_en_n,
    input  logic                      load_n,
    input  logic                      wr_n,
    input  logic                      cs1_n,
    input  logic                      cs2_n,
    input  logic                      cs3,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES-1:0]          lane_we_n,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata,
    output logic                      rvalid
);
    logic              f_valid, p_valid;
    cyc_e              f_kind, p_kind;
    logic [ADDR_W-1:0] f_addr, p_addr;
    logic [LANES-1:0]  f_lanes, p_lanes;

    pss_front #(.AW(ADDR_W), .BW(BURST_W), .NL(LANES)) u_front (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .clk_en_n(clk_en_n),
        .load_n(load_n), .wr_n(wr_n), .cs1_n(cs1_n), .cs2_n(cs2_n),
        .cs3(cs3), .addr(addr), .lane_we_n(lane_we_n),
        .op_valid(f_valid), .op_kind(f_kind), .op_addr(f_addr),
        .op_lanes(f_lanes)
    );

    pss_pipe #(.AW(ADDR_W), .NL(LANES)) u_pipe (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .clk_en_n(clk_en_n),
        .in_valid(f_valid), .in_kind(f_kind), .in_addr(f_addr),
        .in_lanes(f_lanes),
        .out_valid(p_valid), .out_kind(p_kind), .out_addr(p_addr),
        .out_lanes(p_lanes)
    );

    pss_array #(.AW(ADDR_W), .NL(LANES), .LW(LANE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .clk_en_n(clk_en_n),
        .op_valid(p_valid), .op_kind(p_kind), .op_addr(p_addr),
        .op_lanes(p_lanes), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );
endmodule

// File: tb/sim_pipe_sram.sv
`timescale 1ns/1ps
module sim_pipe_sram;
    localparam time        PER    = 20ns;
    localparam logic [2:0] SEL_ON = 3'b001;
    localparam logic [2:0] SEL_OFF = 3'b101;

    logic        clk = 1'b0;
    logic        rst_n, sleep, clk_en_n, load_n, wr_n, cs1_n, cs2_n, cs3;
    logic [7:0]  addr;
    logic [3:0]  lane_we_n;
    logic [35:0] wdata, rdata;
    logic        rvalid;

    pipe_sram u0 (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .clk_en_n(clk_en_n),
        .load_n(load_n), .wr_n(wr_n), .cs1_n(cs1_n), .cs2_n(cs2_n),
        .cs3(cs3), .addr(addr), .lane_we_n(lane_we_n), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    always #(PER/2) clk = ~clk;

    int vectors = 0;
    int misses  = 0;
    int seq     = 0;

    logic [35:0] refm [256];
    logic [7:0]  b_addr = '0;
    logic        b_wr = 1'b0, b_sel = 1'b0;
    logic        p1v = 0, p1w = 0, p2v = 0, p2w = 0;
    logic [7:0]  p1a = '0, p2a = '0;
    logic [3:0]  p1l = '0, p2l = '0;
    logic        exp_v = 1'b0;
    logic [35:0] exp_d = '0;

    function automatic logic [35:0] pat(input logic [7:0] a, input int s);
        logic [7:0] sb;
        sb = 8'(s);
        return {sb[3:0], a, ~a, a ^ sb, a + 8'd3};
    endfunction

    task automatic tick(input logic ld, input logic wrn, input logic [7:0] a,
                        input logic [3:0] bwn, input logic [2:0] sel,
                        input logic hold, input logic slp, input string why);
        @(negedge clk);
        load_n = ld; wr_n = wrn; addr = a; lane_we_n = bwn;
        {cs1_n, cs2_n, cs3} = sel; clk_en_n = hold; sleep = slp;
        seq++;
        wdata = (p2v && p2w) ? pat(p2a, seq) : ~pat(8'hA5, seq);
        @(posedge clk);
        #2;
        if (slp) begin
            p1v = 0; p2v = 0; b_sel = 0; exp_v = 0;
        end else if (!hold) begin
            if (!ld) begin
                b_addr = a; b_wr = !wrn; b_sel = (sel == SEL_ON);
            end else begin
                b_addr[1:0] = b_addr[1:0] + 2'd1;
            end
            if (p2v && p2w)
                for (int i = 0; i < 4; i++)
                    if (p2l[i]) refm[p2a][i*9 +: 9] = wdata[i*9 +: 9];
            exp_v = p2v && !p2w;
            if (exp_v) exp_d = refm[p2a];
            p2v = p1v; p2w = p1w; p2a = p1a; p2l = p1l;
            p1v = b_sel; p1w = b_wr; p1a = b_addr; p1l = ~bwn;
        end
        vectors++;
        if (rvalid !== exp_v) begin
            misses++;
            $display("FAIL %s: rvalid=%0b expected %0b", why, rvalid, exp_v);
        end else if (exp_v && rdata !== exp_d) begin
            misses++;
            $display("FAIL %s: rdata=%h expected %h", why, rdata, exp_d);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 1, 8'h00, 4'hF, SEL_OFF, 0, 0, "R7 idle");
    endtask

    initial begin
        #(PER * 200000);
        misses++;
        $display("FAIL watchdog: run incomplete, expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        rst_n = 0; sleep = 0; clk_en_n = 0; load_n = 0; wr_n = 1;
        {cs1_n, cs2_n, cs3} = SEL_OFF; addr = '0; lane_we_n = 4'hF; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        vectors++;
        if (rvalid !== 1'b0 || rdata !== 36'h0) begin
            misses++;
            $display("FAIL R1 reset: rvalid=%0b rdata=%h expected 0 0", rvalid, rdata);
        end

        // R3: full-word writes to every address
        for (int a = 0; a < 256; a++) tick(0, 0, 8'(a), 4'h0, SEL_ON, 0, 0, "R3 full write");
        idle(2);

        // R2/R6/R5: burst reads, advance cycles carry flipped type and selects
        for (int k = 0; k < 64; k++) begin
            tick(0, 1, 8'(4*k), 4'hF, SEL_ON, 0, 0, "R2 burst read");
            for (int j = 0; j < 3; j++)
                tick(1, 0, 8'hFF, 4'h0, SEL_OFF, 0, 0, "R5 R6 advance");
        end
        idle(2);

        // R6: wrap of the low address bits
        for (int k = 0; k < 16; k++) begin
            tick(0, 1, 8'(4*k + 3), 4'hF, SEL_ON, 0, 0, "R6 wrap load");
            for (int j = 0; j < 3; j++)
                tick(1, 1, 8'h00, 4'hF, SEL_ON, 0, 0, "R6 wrap step");
        end
        idle(2);

        // R3/R9: partial lane writes each read back on the next cycle
        for (int m = 0; m < 16; m++) begin
            tick(0, 0, 8'(16 + m), ~4'(m), SEL_ON, 0, 0, "R3 lane write");
            tick(0, 1, 8'(16 + m), 4'hF, SEL_ON, 0, 0, "R9 read after lane write");
        end
        idle(2);

        // R9: write then read same address, back to back, and write-burst then read-burst
        for (int a = 64; a < 128; a++) begin
            tick(0, 0, 8'(a), 4'h0, SEL_ON, 0, 0, "R9 write");
            tick(0, 1, 8'(a), 4'hF, SEL_ON, 0, 0, "R9 read");
        end
        for (int k = 0; k < 8; k++) begin
            tick(0, 0, 8'(4*k), 4'h0, SEL_ON, 0, 0, "R9 write burst");
            for (int j = 0; j < 3; j++) tick(1, 0, 8'h00, 4'h0, SEL_ON, 0, 0, "R9 write step");
            tick(0, 1, 8'(4*k), 4'hF, SEL_ON, 0, 0, "R9 read burst");
            for (int j = 0; j < 3; j++) tick(1, 1, 8'h00, 4'hF, SEL_ON, 0, 0, "R9 read step");
        end
        idle(2);

        // R4: frozen edges interleaved with reads and writes
        for (int a = 128; a < 160; a++) begin
            tick(0, (a % 2 == 0), 8'(a), 4'h0, SEL_ON, 0, 0, "R4 access");
            tick(0, 0, 8'(a + 1), 4'h0, SEL_ON, 1, 0, "R4 frozen");
            tick(1, 1, 8'hEE, 4'h3, SEL_OFF, 1, 0, "R4 frozen");
        end
        idle(2);
        for (int a = 128; a < 160; a++) tick(0, 1, 8'(a), 4'hF, SEL_ON, 0, 0, "R4 readback");
        idle(2);

        // R5/R7: each chip select alone deselects; advances stay deselected
        for (int v = 0; v < 3; v++) begin
            logic [2:0] s;
            s = (v == 0) ? 3'b101 : (v == 1) ? 3'b011 : 3'b000;
            tick(0, 0, 8'd8, 4'h0, s, 0, 0, "R7 deselected write");
            tick(1, 0, 8'd8, 4'h0, SEL_ON, 0, 0, "R7 deselected step");
            tick(0, 1, 8'd8, 4'hF, s, 0, 0, "R7 deselected read");
            tick(1, 1, 8'd8, 4'hF, SEL_ON, 0, 0, "R7 deselected step");
            idle(2);
            tick(0, 1, 8'd8, 4'hF, SEL_ON, 0, 0, "R7 readback");
            for (int j = 0; j < 3; j++) tick(1, 1, 8'h00, 4'hF, SEL_ON, 0, 0, "R7 readback");
            idle(2);
        end

        // R8: sleep with accesses in flight and attempted during sleep
        tick(0, 0, 8'd200, 4'h0, SEL_ON, 0, 0, "R8 write before sleep");
        tick(0, 1, 8'd201, 4'hF, SEL_ON, 0, 0, "R8 read before sleep");
        for (int i = 0; i < 3; i++)
            tick(0, 0, 8'(200 + i), 4'h0, SEL_ON, 0, 1, "R8 asleep");
        tick(1, 1, 8'h00, 4'hF, SEL_ON, 0, 0, "R8 advance after sleep");
        idle(2);
        tick(0, 1, 8'd200, 4'hF, SEL_ON, 0, 0, "R8 readback");
        for (int j = 0; j < 3; j++) tick(1, 1, 8'h00, 4'hF, SEL_ON, 0, 0, "R8 readback");
        idle(3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule